// File: doc/BRIEF.md
# Serial ADC Host Capture Controller

This block is the host side of a three-wire link to an 8-bit successive-approximation converter with a serial output. It builds the converter clock from the system clock with a programmable divider and drives the active-low start line. It also samples the serial data line and hands each finished conversion to the system as a parallel byte with a one-cycle strobe. One converter frame is twelve converter-clock periods long. After the falling edge of clock 4 the converter shifts out its result, most significant bit first, one bit per period. The least significant bit is valid only for the low half of clock 11. Its value is gone once clock 12 rises.

Every bit is taken in the last system-clock cycle before a converter-clock rising edge. For the first seven bits that point lies mid-window. For the last bit it still falls inside the short low phase, so the same rule covers the whole frame in every start mode. Three start modes are offered. Single-shot runs one frame per request. Synchronized lifts the start line near the end of each frame and lowers it again after the final falling edge. Free-run holds the start line low so that frames follow each other without a gap. The mode is taken when a run begins.

Top module: `sadc_capture`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, adc_clk_o is 0, adc_sc_no is 1, busy_o is 0, valid_o is 0 and data_o is 0.
- R2: While a run is active, every high phase and every low phase of adc_clk_o lasts half_i system cycles, with half_i of 0 treated as 1. When no run is active, adc_clk_o rests low and stays low.
- R3: When an idle block accepts a request, adc_sc_no goes low and busy_o goes high on the same edge. The first converter-clock rising edge follows half_i cycles later, and each frame is exactly 12 rising edges.
- R4: The bits are sampled in the system cycle just before converter rising edges 5 through 12, the first sample being the MSB. The assembled byte equals the word the converter sent.
- R5: valid_o is high for exactly one cycle, the cycle right after rising edge 12. data_o changes only in that cycle and holds its value until the next strobe.
- R6: Mode encodings are 0 = single-shot, 1 = synchronized, 2 = free-run, and 3 acts as single-shot. In single-shot, a req_i high while idle runs one frame. adc_sc_no rises on rising edge 11. The clock stops after falling edge 12, and busy_o drops on that same edge.
- R7: While busy_o is high in single-shot mode, req_i is ignored. A request pulse during a frame yields no second frame and no second strobe.
- R8: In synchronized mode, adc_sc_no rises on rising edge 11 of every frame. If req_i was high at that edge, adc_sc_no falls again on falling edge 12 and the clock keeps running into the next frame.
- R9: In free-run mode, adc_sc_no stays low across frame boundaries while req_i is high at rising edge 11. In the last frame, the first with req_i low at that edge, adc_sc_no rises there and the run ends after falling edge 12.
- R10: mode_i is captured when a run starts. Changing it during a run changes nothing until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Start mode: 0 single-shot, 1 synchronized, 2 free-run, 3 single-shot |
| req_i | input | 1 | Request (single-shot) or keep-running level (repeating modes) |
| half_i | input | DIV_W | Converter clock half period in system cycles, 0 acts as 1; hold stable while busy |
| adc_dout_i | input | 1 | Serial data from the converter |
| adc_clk_o | output | 1 | Converter clock |
| adc_sc_no | output | 1 | Start-convert to the converter, active low |
| data_o | output | WORD_W | Last captured conversion result |
| valid_o | output | 1 | One-cycle strobe for a new data_o |
| busy_o | output | 1 | A run is in progress |

## Verification
The bench drives a behavioural converter that changes its data line 8 ns after each falling edge. That converter also forces the line low 2 ns after rising edge 12, so a controller sampling one system cycle late would read 0 instead of the LSB, and a frame counter that is off by one would shift every byte. Several runs use all-ones, all-zeros and alternating words with half periods of 0, 1, 2, 3 and 5. These catch a divider that mishandles a half period of 0 or 1, or that gives an uneven duty cycle. Any stray converter-clock edge after a single-shot frame is counted. So is a second frame started by a request made while busy, and the wrong number of start-line rises in synchronized or free-run mode, which would show a confusion between the two repeating modes. A mode change during a free run checks that the mode is not sampled again mid-run.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_SYNC   = 2'd1,
    MODE_FREE   = 2'd2,
    MODE_RSVD   = 2'd3
  } sadc_mode_e;

  localparam int unsigned FRAME_LEN = 12;
endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             adc_clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_eff;
  logic             clk_q;
  logic             wrap;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  assign wrap     = (cnt_q == half_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // edge happens at the end of the flagged cycle
  assign rise_o    = run_i & wrap & ~clk_q;
  assign fall_o    = run_i & wrap & clk_q;
  assign adc_clk_o = clk_q;
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       req_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       run_o,
  output logic       sc_no,
  output logic       sample_o,
  output logic       last_o
);
  localparam int unsigned EDGE_W = $clog2(FRAME_LEN + 1);
  localparam logic [EDGE_W-1:0] LAST_E    = EDGE_W'(FRAME_LEN);
  localparam logic [EDGE_W-1:0] RAISE_PRE = EDGE_W'(FRAME_LEN - 2);
  localparam logic [EDGE_W-1:0] SAMP_LO   = EDGE_W'(FRAME_LEN - WORD_W);
  localparam logic [EDGE_W-1:0] SAMP_HI   = EDGE_W'(FRAME_LEN - 1);

  logic              run_q;
  logic              sc_q;
  logic              cont_q;
  sadc_mode_e        mode_q;
  logic [EDGE_W-1:0] edge_q;
  logic              repeat_c;

  assign repeat_c = (mode_q == MODE_SYNC) || (mode_q == MODE_FREE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      sc_q   <= 1'b1;
      cont_q <= 1'b0;
      mode_q <= MODE_SINGLE;
      edge_q <= '0;
    end else if (!run_q) begin
      if (req_i) begin
        run_q  <= 1'b1;
        sc_q   <= 1'b0;
        cont_q <= 1'b0;
        edge_q <= '0;
        mode_q <= sadc_mode_e'(mode_i);
      end
    end else begin
      if (rise_i) begin
        edge_q <= edge_q + EDGE_W'(1);
        if (edge_q == RAISE_PRE) begin
          cont_q <= repeat_c && req_i;
          sc_q   <= !((mode_q == MODE_FREE) && req_i);
        end
      end
      if (fall_i && edge_q == LAST_E) begin
        edge_q <= '0;
        if (cont_q) sc_q  <= 1'b0;
        else        run_q <= 1'b0;
      end
    end
  end

  assign run_o    = run_q;
  assign sc_no    = sc_q;
  assign sample_o = rise_i && (edge_q >= SAMP_LO) && (edge_q <= SAMP_HI);
  assign last_o   = rise_i && (edge_q == SAMP_HI);
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_nxt;
  logic [WORD_W-1:0] data_q;
  logic              valid_q;

  assign sr_nxt = {sr_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last_i;
      if (sample_i) sr_q   <= sr_nxt;
      if (last_i)   data_q <= sr_nxt;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture
  import sadc_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              req_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              adc_dout_i,
  output logic              adc_clk_o,
  output logic              adc_sc_no,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o
);
  logic run, rise, fall, sample, last;

  sadc_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .half_i    (half_i),
    .adc_clk_o (adc_clk_o),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  sadc_seq #(.WORD_W(WORD_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .req_i    (req_i),
    .rise_i   (rise),
    .fall_i   (fall),
    .run_o    (run),
    .sc_no    (adc_sc_no),
    .sample_o (sample),
    .last_o   (last)
  );

  sadc_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .last_i   (last),
    .bit_i    (adc_dout_i),
    .data_o   (data_o),
    .valid_o  (valid_o)
  );

  assign busy_o = run;
endmodule

// File: rtl/sadc_capture_chk.sv
module sadc_capture_chk #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DIV_W-1:0]  half_i,
  input logic              adc_clk_o,
  input logic              adc_sc_no,
  input logic [WORD_W-1:0] data_o,
  input logic              valid_o,
  input logic              busy_o
);
  logic [DIV_W:0]   hi_cnt;
  logic [DIV_W-1:0] half_eff;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (adc_clk_o) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  AST_HIGH_PHASE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_clk_o) |-> hi_cnt == {1'b0, half_eff}); // R2
  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !adc_clk_o); // R2
  AST_START_WITH_SC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !adc_sc_no); // R3
  AST_SC_FALL_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_sc_no) |-> !adc_clk_o); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R5
  AST_STOP_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $fell(adc_clk_o)); // R6
  AST_IDLE_SC_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> adc_sc_no); // R6
endmodule

bind sadc_capture sadc_capture_chk #(.WORD_W(WORD_W), .DIV_W(DIV_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .half_i    (half_i),
  .adc_clk_o (adc_clk_o),
  .adc_sc_no (adc_sc_no),
  .data_o    (data_o),
  .valid_o   (valid_o),
  .busy_o    (busy_o)
);

// File: tb/test_sadc_capture.sv
`timescale 1ns/1ps
module test_sadc_capture;
  localparam int  WORD_W = 8;
  localparam int  DIV_W  = 8;
  localparam time TCLK   = 20ns;
  // {mode, half, base word}
  localparam logic [13:0] VEC [8] = '{
    {2'd0, 4'd2, 8'hA5}, {2'd0, 4'd1, 8'h00}, {2'd1, 4'd2, 8'hFF}, {2'd2, 4'd3, 8'h3C},
    {2'd1, 4'd1, 8'h80}, {2'd2, 4'd2, 8'h01}, {2'd0, 4'd0, 8'hC3}, {2'd3, 4'd5, 8'h5A}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        mode_i = 2'd0;
  logic              req_i = 1'b0;
  logic [DIV_W-1:0]  half_i = 8'd2;
  logic              adc_dout_i = 1'b0;
  logic              adc_clk_o, adc_sc_no, valid_o, busy_o;
  logic [WORD_W-1:0] data_o;

  always #10 clk_i = ~clk_i;

  sadc_capture #(.WORD_W(WORD_W), .DIV_W(DIV_W)) i_sadc_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .req_i(req_i), .half_i(half_i),
    .adc_dout_i(adc_dout_i), .adc_clk_o(adc_clk_o), .adc_sc_no(adc_sc_no),
    .data_o(data_o), .valid_o(valid_o), .busy_o(busy_o)
  );

  int  checks = 0, fails = 0;
  bit  done = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] word_of(logic [7:0] b, int n);
    return b ^ 8'(n * 91);
  endfunction

  // converter model
  bit         m_act = 1'b0;
  int         m_cnt = 0, m_frames = 0, stray = 0;
  logic [7:0] m_word = 8'h00, m_base = 8'h00;

  always @(posedge adc_clk_o) begin
    if (!m_act || m_cnt == 12) begin
      if (!adc_sc_no) begin
        m_act = 1'b1; m_cnt = 1;
        m_word = word_of(m_base, m_frames);
        m_frames++;
      end else begin
        m_act = 1'b0; stray++;
      end
    end else begin
      m_cnt++;
      if (m_cnt == 12) adc_dout_i <= #2 1'b0;
    end
  end

  always @(negedge adc_clk_o) begin
    if (m_act && m_cnt >= 4 && m_cnt <= 11) adc_dout_i <= #8 m_word[11 - m_cnt];
    else if (m_act && m_cnt == 12 && adc_sc_no) m_act = 1'b0;
  end

  // monitors
  int         vcount = 0, duty_err = 0, sc_rises = 0;
  logic [7:0] got [8];
  time        t_rise = 0, exp_hi = 40ns;

  always @(negedge clk_i) if (rst_ni && valid_o) begin
    if (vcount < 8) got[vcount] = data_o;
    vcount++;
  end
  always @(posedge adc_clk_o) t_rise = $time;
  always @(negedge adc_clk_o) if ($time - t_rise != exp_hi) duty_err++;
  always @(posedge adc_sc_no) sc_rises++;

  task automatic clear_mon(int heff);
    exp_hi = heff * TCLK;
    m_frames = 0; vcount = 0; stray = 0; duty_err = 0; sc_rises = 0;
  endtask

  task automatic wait_idle(int heff);
    while (busy_o) @(negedge clk_i);
    repeat (4 * heff + 4) @(negedge clk_i);
  endtask

  task automatic run_vec(logic [1:0] md, int h, logic [7:0] b);
    int heff = (h == 0) ? 1 : h;
    int nexp;
    mode_i = md; half_i = 8'(h); m_base = b;
    clear_mon(heff);
    @(negedge clk_i);
    if (md == 2'd1 || md == 2'd2) begin
      req_i = 1'b1;
      wait (vcount >= 2);
      @(negedge clk_i);
      req_i = 1'b0;
      nexp = 3;
    end else begin
      req_i = 1'b1; @(negedge clk_i); req_i = 1'b0;
      repeat (6) @(negedge clk_i);
      req_i = 1'b1; @(negedge clk_i); req_i = 1'b0;  // R7 request while busy
      nexp = 1;
    end
    wait_idle(heff);
    if (md == 2'd1)      check(vcount == 3, "R8 frame count", vcount, 3);
    else if (md == 2'd2) check(vcount == 3, "R9 frame count", vcount, 3);
    else                 check(vcount == 1, "R7 R6 single frame count", vcount, 1);
    for (int k = 0; k < nexp && k < vcount; k++)
      check(got[k] == word_of(b, k), "R4 captured word", got[k], word_of(b, k));
    check(m_frames == nexp, "R3 frames seen by converter", m_frames, nexp);
    check(stray == 0, "R6 stray clock edges", stray, 0);
    check(duty_err == 0, "R2 high phase length", duty_err, 0);
    check(adc_clk_o == 1'b0 && adc_sc_no == 1'b1 && busy_o == 1'b0,
          "R2 idle pins", {adc_clk_o, adc_sc_no, busy_o}, 3'b010);
    check(data_o == word_of(b, nexp - 1), "R5 data hold", data_o, word_of(b, nexp - 1));
    if (md == 2'd1)      check(sc_rises == 3, "R8 start line rises", sc_rises, 3);
    else if (md == 2'd2) check(sc_rises == 1, "R9 start line rises", sc_rises, 1);
  endtask

  initial begin
    #(200000 * TCLK);
    check(1'b0, "watchdog R6", 0, 1);
    summary();
  end

  initial begin
    #35ns;
    check(adc_clk_o == 0 && adc_sc_no == 1 && busy_o == 0 && valid_o == 0 && data_o == 0,
          "R1 reset state", {adc_clk_o, adc_sc_no, busy_o, valid_o}, 4'b0100);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check(adc_clk_o == 0 && adc_sc_no == 1 && busy_o == 0 && valid_o == 0 && data_o == 0,
          "R1 after release", {adc_clk_o, adc_sc_no, busy_o, valid_o}, 4'b0100);

    for (int i = 0; i < 8; i++)
      run_vec(VEC[i][13:12], int'(VEC[i][11:8]), VEC[i][7:0]);

    // R10: free run, mode switched to single-shot mid-run
    mode_i = 2'd2; half_i = 8'd2; m_base = 8'h96;
    clear_mon(2);
    @(negedge clk_i); req_i = 1'b1;
    @(negedge clk_i); mode_i = 2'd0;
    wait (vcount >= 2);
    @(negedge clk_i); req_i = 1'b0;
    wait_idle(2);
    check(vcount == 3, "R10 frames after mode change", vcount, 3);
    check(sc_rises == 1, "R10 start line rises", sc_rises, 1);
    check(got[2] == word_of(8'h96, 2), "R10 last word", got[2], word_of(8'h96, 2));

    summary();
  end
endmodule